// File: doc/BRIEF.md
# Petri Net Supervisory Controller

This block runs a fixed, safe Petri net of four places and five transitions as a clocked discrete-event controller. The marking sits in a register of one bit per place. Every cycle the block decides which transitions may fire: each transition has a set of input places (its consumption mask), a set of output places (its production mask) and a guard. A transition can fire only when all of its input places hold a token and its guard is true. The guard is the external input bit, the inverse of that bit, or a residence timer that measures how long the transition's input place has been marked.

The net has three timed transitions that form a loop, p1→p2→p3→p1, plus an input-driven branch, p1→p4→p1. Entering p4 is requested by the input bit, and the return to p1 is requested by its inverse. The residence timers count a slow tick pulse, such as a 10 ms strobe, so the default timeout of 50 ticks gives half a second. The branch transition out of p1 has priority over the timed transition out of p1. The marking is also mapped to output bits through a per-output place mask. An output is the OR of every place selected by its mask.

Top module: `pn_supervisor`

## Requirements
- R1: Reset is synchronous and active high. After a clock edge with `rst` high, `marking` is 4'b0001: place p1 (bit 0) holds the token and p2, p3 and p4 (bits 1, 2, 3) are empty.
- R2: A transition fires only when all of its input places are marked and its guard is true. Firing clears its input places and sets its output places at the next clock edge. When no transition fires, the marking does not change. The transitions are t1: p1→p2, t2: p2→p3, t3: p3→p1, t4: p1→p4 and t5: p4→p1.
- R3: t4's guard is `in_bit`=1, so with p1 marked the token moves to p4 at the next edge. t5's guard is `in_bit`=0, so with p4 marked and `in_bit` high the marking holds, and once `in_bit` is low the token returns to p1 at the next edge.
- R4: t1, t2 and t3 are timed from p1, p2 and p3 respectively. While its place stays marked, a timer counts the cycles in which `tick` is high, and stops counting at TIMEOUT. Cycles without `tick` do not advance it. After the edge that brings the count to TIMEOUT, the transition fires at the next edge, unless a higher-priority transition fires first.
- R5: A timer clears whenever its place is unmarked. A partial count is lost when the token leaves, and a re-marked place needs a full TIMEOUT ticks again.
- R6: When t4 and t1 are both enabled in the same cycle, t4 fires and the token goes to p4.
- R7: At most one transition fires per edge. Among enabled transitions other than t4, the lowest index wins. Exactly one place is marked at every cycle after reset.
- R8: `out_bits[k]` is the OR of the marked places selected by mask k. It follows `marking` in the same cycle. The default masks give out0=p1, out1=p2, out2=p3 and out3=p1 OR p3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Single-cycle time-base strobe for the residence timers |
| in_bit | input | 1 | External input bit; guard of t4, and inverted guard of t5 |
| out_bits | output | NOUT | Place-to-output mapped bits |
| marking | output | NP | Current marking, one bit per place (bit 0 = p1) |

## Verification
Only one real conflict can arise in this net: the timeout of p1 and a high `in_bit` both want the single token in p1. The bench ticks p1's timer up to its limit while holding `in_bit` low. In the very next cycle it raises `in_bit`, so that t1 and t4 are enabled together. The bench then checks that the token lands in p4 and not in p2. A long randomized run, with bursty input changes, irregular ticks and a reset in the middle, compares every cycle against an arithmetic model in the bench. This catches every other case where a timeout and an input edge fall together.

// File: rtl/pn_pkg.sv
package pn_pkg;

    localparam int NP = 4;
    localparam int NT = 5;
    localparam int PW = $clog2(NP);
    localparam int PRIO_T = 3;

    typedef logic [NP-1:0] mark_t;
    typedef logic [NT-1:0] tvec_t;

    typedef enum logic [1:0] {
        G_ALWAYS  = 2'd0,
        G_INPUT   = 2'd1,
        G_INPUT_N = 2'd2,
        G_TIMER   = 2'd3
    } guard_e;

    typedef struct packed {
        mark_t           pre;
        mark_t           post;
        guard_e          guard;
        logic [PW-1:0]   tplace;
    } trans_t;

    localparam mark_t INIT_MARK = 4'b0001;

    function automatic trans_t mk(mark_t pre, mark_t post, guard_e g, int unsigned p);
        trans_t c;
        c.pre    = pre;
        c.post   = post;
        c.guard  = g;
        c.tplace = PW'(p);
        return c;
    endfunction

    // Transition table of the supervised net.
    function automatic trans_t net_cfg(int t);
        case (t)
            0:       return mk(4'b0001, 4'b0010, G_TIMER,   0);
            1:       return mk(4'b0010, 4'b0100, G_TIMER,   1);
            2:       return mk(4'b0100, 4'b0001, G_TIMER,   2);
            3:       return mk(4'b0001, 4'b1000, G_INPUT,   0);
            4:       return mk(4'b1000, 4'b0001, G_INPUT_N, 0);
            default: return mk('0, '0, G_ALWAYS, 0);
        endcase
    endfunction

    function automatic logic pre_ok(mark_t m, trans_t c);
        return (m & c.pre) == c.pre;
    endfunction

    function automatic logic guard_ok(trans_t c, logic in_bit, mark_t expired);
        case (c.guard)
            G_INPUT:   return in_bit;
            G_INPUT_N: return ~in_bit;
            G_TIMER:   return expired[c.tplace];
            default:   return 1'b1;
        endcase
    endfunction

    function automatic mark_t fire_next(mark_t m, trans_t c);
        return (m & ~c.pre) | c.post;
    endfunction

endpackage

// File: rtl/pn_place_timer.sv
module pn_place_timer #(
    parameter int TIMEOUT = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic marked,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !marked) begin
            cnt <= '0;
        end else if (tick && cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = marked && (cnt == LIMIT);

    // R5: an empty place leaves its timer at zero on the next cycle
    a_r5_clear_when_empty: assert property (@(posedge clk) disable iff (rst)
        !marked |=> (cnt == '0));

    // R4: the count moves only on tick cycles
    a_r4_tick_only: assert property (@(posedge clk) disable iff (rst)
        (marked && !tick) |=> $stable(cnt));

endmodule

// File: rtl/pn_fire_arbiter.sv
module pn_fire_arbiter
    import pn_pkg::*;
(
    input  mark_t marking,
    input  logic  in_bit,
    input  mark_t expired,
    output tvec_t enabled,
    output tvec_t fire
);
    for (genvar t = 0; t < NT; t++) begin : g_en
        localparam trans_t C = net_cfg(t);
        assign enabled[t] = pre_ok(marking, C) && guard_ok(C, in_bit, expired);
    end

    always_comb begin
        logic found;
        fire  = '0;
        found = 1'b0;
        if (enabled[PRIO_T]) begin
            fire[PRIO_T] = 1'b1;
        end else begin
            for (int t = 0; t < NT; t++) begin
                if (!found && enabled[t]) begin
                    fire[t] = 1'b1;
                    found   = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pn_out_map.sv
module pn_out_map
    import pn_pkg::*;
#(
    parameter int NOUT = 4,
    parameter logic [NOUT*NP-1:0] OUT_MASK = 16'b0101_0100_0010_0001
) (
    input  mark_t            marking,
    output logic [NOUT-1:0]  out_bits
);
    for (genvar k = 0; k < NOUT; k++) begin : g_out
        assign out_bits[k] = |(marking & OUT_MASK[k*NP +: NP]);
    end
endmodule

// File: rtl/pn_supervisor.sv
module pn_supervisor
    import pn_pkg::*;
#(
    parameter int TIMEOUT = 50,
    parameter int NOUT = 4,
    parameter logic [NOUT*NP-1:0] OUT_MASK = 16'b0101_0100_0010_0001
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            in_bit,
    output logic [NOUT-1:0] out_bits,
    output logic [NP-1:0]   marking
);
    mark_t mark_q;
    mark_t mark_d;
    mark_t expired;
    tvec_t enabled;
    tvec_t fire;

    for (genvar p = 0; p < NP; p++) begin : g_timer
        pn_place_timer #(.TIMEOUT(TIMEOUT)) u_timer (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .marked  (mark_q[p]),
            .expired (expired[p])
        );
    end

    pn_fire_arbiter u_arb (
        .marking (mark_q),
        .in_bit  (in_bit),
        .expired (expired),
        .enabled (enabled),
        .fire    (fire)
    );

    always_comb begin
        mark_d = mark_q;
        for (int t = 0; t < NT; t++) begin
            if (fire[t]) mark_d = fire_next(mark_q, net_cfg(t));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mark_q <= INIT_MARK;
        else     mark_q <= mark_d;
    end

    pn_out_map #(.NOUT(NOUT), .OUT_MASK(OUT_MASK)) u_out (
        .marking  (mark_q),
        .out_bits (out_bits)
    );

    assign marking = mark_q;

    // R1: reset loads the initial marking
    a_r1_reset_init: assert property (@(posedge clk)
        rst |=> (marking == INIT_MARK));

    // R7: never more than one firing per cycle
    a_r7_single_fire: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fire));

    // R7: the net keeps exactly one token
    a_r7_one_token: assert property (@(posedge clk) disable iff (rst)
        $countones(marking) == 1);

    // R6: an enabled priority transition always wins
    a_r6_prio_wins: assert property (@(posedge clk) disable iff (rst)
        enabled[PRIO_T] |-> fire[PRIO_T]);

    // R2: no firing means the marking holds
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (fire == '0) |=> $stable(marking));

    for (genvar t = 0; t < NT; t++) begin : g_chk
        localparam trans_t C = net_cfg(t);
        // R2: a firing never takes a token from an empty place
        a_r2_no_underflow: assert property (@(posedge clk) disable iff (rst)
            fire[t] |-> ((marking & C.pre) == C.pre));
        // R2: a firing never puts a second token in a marked place
        a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
            fire[t] |-> ((marking & ~C.pre & C.post) == '0));
    end

endmodule

// File: tb/tb_pn_supervisor.sv
module tb_pn_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int TO = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       in_bit = 1'b0;
    logic [3:0] out_bits;
    logic [3:0] marking;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [3:0] em;
    int         ecnt [4];

    pn_supervisor #(.TIMEOUT(TO)) dut (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .in_bit   (in_bit),
        .out_bits (out_bits),
        .marking  (marking)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [3:0] exp_out(logic [3:0] m);
        return {m[0] | m[2], m[2], m[1], m[0]};
    endfunction

    task automatic chk(string req, logic [3:0] got, logic [3:0] want);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, want, $time);
        end
    endtask

    // Arithmetic model of one edge with the given inputs.
    task automatic model_step(logic r, logic i, logic t);
        logic [3:0] ex;
        logic [4:0] en;
        logic [3:0] nm;
        if (r) begin
            em = 4'b0001;
            for (int p = 0; p < 4; p++) ecnt[p] = 0;
            return;
        end
        for (int p = 0; p < 4; p++) ex[p] = em[p] && (ecnt[p] == TO);
        en[0] = em[0] && ex[0];
        en[1] = em[1] && ex[1];
        en[2] = em[2] && ex[2];
        en[3] = em[0] && i;
        en[4] = em[3] && !i;
        nm = em;
        if (en[3])      nm = 4'b1000;
        else if (en[0]) nm = 4'b0010;
        else if (en[1]) nm = 4'b0100;
        else if (en[2]) nm = 4'b0001;
        else if (en[4]) nm = 4'b0001;
        for (int p = 0; p < 4; p++) begin
            if (!em[p])                 ecnt[p] = 0;
            else if (t && ecnt[p] < TO) ecnt[p] = ecnt[p] + 1;
        end
        em = nm;
    endtask

    // Drive inputs at a falling edge, run one rising edge, sample at the next falling edge.
    task automatic cyc(logic r, logic i, logic t);
        rst = r; in_bit = i; tick = t;
        model_step(r, i, t);
        @(negedge clk);
    endtask

    task automatic ticks(int n, logic i);
        for (int k = 0; k < n; k++) cyc(1'b0, i, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        em = 4'b0001;
        for (int p = 0; p < 4; p++) ecnt[p] = 0;
        @(negedge clk);
        cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b1, 1'b0, 1'b0);
        // R1 reset state
        chk("R1", marking, 4'b0001);
        chk("R8", out_bits, 4'b1001);

        // R3 input branch
        cyc(1'b0, 1'b1, 1'b0);
        chk("R3", marking, 4'b1000);
        chk("R8", out_bits, 4'b0000);
        cyc(1'b0, 1'b1, 1'b0);
        chk("R3", marking, 4'b1000);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R3", marking, 4'b0001);

        // R4 timed loop, with a gap between ticks
        ticks(TO - 1, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R4", marking, 4'b0001);
        ticks(1, 1'b0);
        chk("R4", marking, 4'b0001);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R4", marking, 4'b0010);
        chk("R8", out_bits, 4'b0010);
        ticks(TO, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R4", marking, 4'b0100);
        chk("R8", out_bits, 4'b1100);
        ticks(TO, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R2", marking, 4'b0001);

        // R5 timer restart after leaving p1
        ticks(TO - 1, 1'b0);
        cyc(1'b0, 1'b1, 1'b0);
        chk("R5", marking, 4'b1000);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R5", marking, 4'b0001);
        ticks(TO - 1, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R5", marking, 4'b0001);
        ticks(1, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R5", marking, 4'b0010);
        ticks(TO, 1'b0); cyc(1'b0, 1'b0, 1'b0);
        ticks(TO, 1'b0); cyc(1'b0, 1'b0, 1'b0);
        chk("R4", marking, 4'b0001);

        // R6 timeout of p1 and in_bit in the same cycle
        ticks(TO, 1'b0);
        cyc(1'b0, 1'b1, 1'b0);
        chk("R6", marking, 4'b1000);
        cyc(1'b0, 1'b0, 1'b0);
        chk("R6", marking, 4'b0001);

        // R2 R7 R8 randomized sweep against the model
        begin
            logic ri = 1'b0;
            void'($urandom(32'h5eed_0042));
            for (int n = 0; n < 4000; n++) begin
                if (($urandom % 8) == 0) ri = ~ri;
                cyc((n == 2000) ? 1'b1 : 1'b0, ri, 1'($urandom % 2));
                chk("R2", marking, em);
                chk("R8", out_bits, exp_out(em));
                chk("R7", 4'($countones(marking)), 4'd1);
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule